// File: doc/BRIEF.md
# SECDED Hamming Codec for 16-bit Words

This block protects a 16-bit memory word with a 22-bit single-error-correcting, double-error-detecting code. It has two independent streaming paths. The encode path takes a data word and returns its six check bits together with the full codeword ready to be stored. The decode path takes a stored codeword and returns four things: the repaired data, the repaired codeword, the 5-bit syndrome and a 2-bit error class.

Each path is a valid/ready stream with one register stage. An item is transferred on any rising clock edge where valid and ready are both high. A path's input ready is high whenever its output register is empty or its output is being taken in the same cycle. While an output is offered and not taken, it holds steady. A full register therefore stalls the input without losing or duplicating items. The two paths share only the clock and reset.

Top module: `secded22_codec`

## Requirements
- R1: Check bits P0..P4 are XOR reductions of the data word under fixed masks: P0 uses mask 0xAD5B, P1 uses 0x366D, P2 uses 0xC78E, P3 uses 0x07F0 and P4 uses 0xF800. Mask bit i selects data bit Di. The encode output check vector carries P0..P4 in bits 4:0.
- R2: P5 is the XOR of all sixteen data bits and P0..P4, and is carried in bit 5 of the check vector. Every codeword produced by the encoder therefore has even weight.
- R3: Codeword layout: bit 0 is P5, and bits 1, 2, 4, 8 and 16 are P0, P1, P2, P3 and P4. D0..D15 occupy positions 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15, 17, 18, 19, 20 and 21, in ascending order.
- R4: On each path, an item accepted on a clock edge is offered at the output with valid high from that edge on. Input ready equals (not output valid) or output ready. An offered output that is not taken keeps valid and its payload unchanged.
- R5: A synchronous active-high reset clears both output valids on the next edge, discarding any held item.
- R6: The decoder syndrome bit j is the received Pj XORed with Pj recomputed from the received data bits. The overall check is the XOR of all 22 received bits. When both are zero, the class is 0 (none) and the word passes unchanged.
- R7: When the syndrome is in the range 1..21 and the overall check is one, the class is 1 (single). The codeword bit at the index equal to the syndrome is inverted, whether it holds data or a check bit.
- R8: When the syndrome is nonzero and the overall check is zero, the class is 2 (double). The codeword is returned exactly as received.
- R9: When the syndrome is zero and the overall check is one, the class is 3 (overall parity only). Only codeword bit 0 is inverted.
- R10: When the syndrome is 22..31 and the overall check is one, the class is 2 (double). The codeword is returned as received.
- R11: The decoder's data output is the sixteen data positions of its output codeword, taken in the R3 order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_in_valid | input | 1 | Encode input item present |
| enc_in_ready | output | 1 | Encode path can take an item |
| enc_in_data | input | 16 | Data word to encode |
| enc_out_valid | output | 1 | Encode result offered |
| enc_out_ready | input | 1 | Consumer takes the encode result |
| enc_out_check | output | 6 | Check bits, P0..P4 in 4:0, P5 in 5 |
| enc_out_code | output | 22 | Codeword in the R3 layout |
| dec_in_valid | input | 1 | Decode input item present |
| dec_in_ready | output | 1 | Decode path can take an item |
| dec_in_code | input | 22 | Received codeword |
| dec_out_valid | output | 1 | Decode result offered |
| dec_out_ready | input | 1 | Consumer takes the decode result |
| dec_out_data | output | 16 | Repaired data word |
| dec_out_code | output | 22 | Repaired (or unchanged) codeword |
| dec_out_syndrome | output | 5 | Syndrome of the received word |
| dec_out_class | output | 2 | 0 none, 1 single, 2 double, 3 overall parity only |

## Verification
Some properties are checked on every clock cycle. On each decoded item, the output codeword must differ from the accepted input in exactly the way the reported class allows: no bits, one bit, or only bit 0. Every encoder output and every repaired word must have even weight. Stalled outputs must hold, and accepted items must appear after one edge. The bench scenarios are what show that the check-bit equations, the bit layout and the syndrome values are the right ones. These include every single-bit position, paired flips, and a three-bit flip that pushes the syndrome past 21. The scenarios also show ordering under random back-pressure and reset that discards a held item.

// File: rtl/secded22_pkg.sv
package secded22_pkg;

  localparam int DATA_W = 16;
  localparam int PAR_W  = 5;
  localparam int CHK_W  = PAR_W + 1;
  localparam int CW_W   = DATA_W + PAR_W + 1;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_DOUBLE = 2'd2,
    ERR_PARITY = 2'd3
  } err_class_e;

  // Index of data bit idx: the idx-th position from 3 upward that is not a power of two.
  function automatic int data_pos(input int idx);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int p = 3; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) res = p;
        n++;
      end
    end
    return res;
  endfunction

  // Data bits covered by check bit j: those whose position has bit j set.
  function automatic logic [DATA_W-1:0] cover_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((data_pos(i) >> j) & 1) != 0;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] pull_data(input logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < DATA_W; i++) d[i] = cw[data_pos(i)];
    return d;
  endfunction

endpackage

// File: rtl/secded22_stage.sv
module secded22_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else if (in_ready) vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) dat_q <= in_data;
  end

  // R4: a refused output stays offered with the same payload
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: an accepted item is offered after the edge
  p_take_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/secded22_enc.sv
module secded22_enc
  import secded22_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CHK_W-1:0]  check_out,
  output logic [CW_W-1:0]   code_out
);

  logic [PAR_W-1:0] grp;
  logic             total;

  genvar j;
  generate
    for (j = 0; j < PAR_W; j++) begin : g_grp
      localparam logic [DATA_W-1:0] MASK = cover_mask(j);
      assign grp[j] = ^(data_in & MASK);
    end
  endgenerate

  assign total     = ^{data_in, grp};
  assign check_out = {total, grp};

  always_comb begin
    code_out    = '0;
    code_out[0] = total;
    for (int i = 0; i < DATA_W; i++) code_out[data_pos(i)] = data_in[i];
    for (int k = 0; k < PAR_W; k++) code_out[1 << k] = grp[k];
  end

endmodule

// File: rtl/secded22_dec.sv
module secded22_dec
  import secded22_pkg::*;
(
  input  logic [CW_W-1:0]   rx_code,
  output logic [DATA_W-1:0] fix_data,
  output logic [CW_W-1:0]   fix_code,
  output logic [PAR_W-1:0]  syndrome,
  output err_class_e        err_cls
);

  localparam logic [PAR_W-1:0] MAX_POS = PAR_W'(CW_W - 1);

  logic [DATA_W-1:0] rx_data;
  logic              overall;

  assign rx_data = pull_data(rx_code);
  assign overall = ^rx_code;

  genvar j;
  generate
    for (j = 0; j < PAR_W; j++) begin : g_syn
      localparam logic [DATA_W-1:0] MASK = cover_mask(j);
      assign syndrome[j] = rx_code[1 << j] ^ (^(rx_data & MASK));
    end
  endgenerate

  always_comb begin
    err_cls  = ERR_NONE;
    fix_code = rx_code;
    if (syndrome == '0) begin
      if (overall) begin
        err_cls     = ERR_PARITY;
        fix_code[0] = ~rx_code[0];
      end
    end else if (!overall || (syndrome > MAX_POS)) begin
      err_cls = ERR_DOUBLE;
    end else begin
      err_cls  = ERR_SINGLE;
      fix_code = rx_code ^ (CW_W'(1) << syndrome);
    end
  end

  assign fix_data = pull_data(fix_code);

endmodule

// File: rtl/secded22_codec.sv
module secded22_codec
  import secded22_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enc_in_valid,
  output logic        enc_in_ready,
  input  logic [15:0] enc_in_data,
  output logic        enc_out_valid,
  input  logic        enc_out_ready,
  output logic [5:0]  enc_out_check,
  output logic [21:0] enc_out_code,
  input  logic        dec_in_valid,
  output logic        dec_in_ready,
  input  logic [21:0] dec_in_code,
  output logic        dec_out_valid,
  input  logic        dec_out_ready,
  output logic [15:0] dec_out_data,
  output logic [21:0] dec_out_code,
  output logic [4:0]  dec_out_syndrome,
  output logic [1:0]  dec_out_class
);

  localparam int ENC_PW = CHK_W + CW_W;
  localparam int DEC_PW = DATA_W + CW_W + PAR_W + 2;

  // encode path
  logic [CHK_W-1:0]  enc_chk;
  logic [CW_W-1:0]   enc_cw;
  logic [ENC_PW-1:0] enc_pay;

  secded22_enc u_enc (
    .data_in  (enc_in_data),
    .check_out(enc_chk),
    .code_out (enc_cw)
  );

  secded22_stage #(.W(ENC_PW)) u_enc_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (enc_in_valid),
    .in_ready (enc_in_ready),
    .in_data  ({enc_chk, enc_cw}),
    .out_valid(enc_out_valid),
    .out_ready(enc_out_ready),
    .out_data (enc_pay)
  );

  assign enc_out_check = enc_pay[ENC_PW-1 -: CHK_W];
  assign enc_out_code  = enc_pay[CW_W-1:0];

  // decode path
  logic [DATA_W-1:0] dec_d;
  logic [CW_W-1:0]   dec_cw;
  logic [PAR_W-1:0]  dec_syn;
  err_class_e        dec_cls;
  logic [DEC_PW-1:0] dec_pay;

  secded22_dec u_dec (
    .rx_code (dec_in_code),
    .fix_data(dec_d),
    .fix_code(dec_cw),
    .syndrome(dec_syn),
    .err_cls (dec_cls)
  );

  secded22_stage #(.W(DEC_PW)) u_dec_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (dec_in_valid),
    .in_ready (dec_in_ready),
    .in_data  ({dec_d, dec_cw, dec_syn, dec_cls}),
    .out_valid(dec_out_valid),
    .out_ready(dec_out_ready),
    .out_data (dec_pay)
  );

  assign dec_out_data     = dec_pay[DEC_PW-1 -: DATA_W];
  assign dec_out_code     = dec_pay[CW_W+PAR_W+1 : PAR_W+2];
  assign dec_out_syndrome = dec_pay[PAR_W+1:2];
  assign dec_out_class    = dec_pay[1:0];

  // R5: reset empties both output registers
  p_reset_clear_r5: assert property (@(posedge clk)
    rst |=> (!enc_out_valid && !dec_out_valid));

  // R2: encoder codewords have even weight
  p_enc_even_r2: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> !(^enc_out_code));

  // R7: a repaired or clean word has even weight
  p_dec_even_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_out_valid && dec_out_class != 2'd2) |-> !(^dec_out_code));

  // R8: none and double classes leave the accepted word untouched
  p_dec_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_in_valid && dec_in_ready) |=>
      (!(dec_out_class == 2'd0 || dec_out_class == 2'd2) ||
       (dec_out_code == $past(dec_in_code))));

  // R7: single class inverts exactly one bit
  p_dec_one_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_in_valid && dec_in_ready) |=>
      ((dec_out_class != 2'd1) ||
       ($countones(dec_out_code ^ $past(dec_in_code)) == 1)));

  // R9: overall-parity class inverts bit 0 only
  p_dec_p5_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_in_valid && dec_in_ready) |=>
      ((dec_out_class != 2'd3) ||
       ((dec_out_code ^ $past(dec_in_code)) == 22'd1)));

  // R10: a single class never carries a syndrome beyond the word
  p_dec_range_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_out_valid && dec_out_class == 2'd1) |->
      (dec_out_syndrome != 5'd0 && dec_out_syndrome <= 5'd21));

endmodule

// File: tb/secded22_codec_tb_top.sv
module secded22_codec_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int DPOS [16]  = '{3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15, 17, 18, 19, 20, 21};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_in_valid = 1'b0;
  logic        enc_in_ready;
  logic [15:0] enc_in_data = '0;
  logic        enc_out_valid;
  logic        enc_out_ready = 1'b1;
  logic [5:0]  enc_out_check;
  logic [21:0] enc_out_code;
  logic        dec_in_valid = 1'b0;
  logic        dec_in_ready;
  logic [21:0] dec_in_code = '0;
  logic        dec_out_valid;
  logic        dec_out_ready = 1'b1;
  logic [15:0] dec_out_data;
  logic [21:0] dec_out_code;
  logic [4:0]  dec_out_syndrome;
  logic [1:0]  dec_out_class;

  int checks   = 0;
  int failures = 0;
  int bp_mode  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded22_codec dut_i (
    .clk(clk), .rst(rst),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
    .enc_out_check(enc_out_check), .enc_out_code(enc_out_code),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_code(dec_in_code),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_data(dec_out_data), .dec_out_code(dec_out_code),
    .dec_out_syndrome(dec_out_syndrome), .dec_out_class(dec_out_class)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model from the requirements
  function automatic logic [15:0] mask_of(input int j);
    case (j)
      0: return 16'hAD5B;
      1: return 16'h366D;
      2: return 16'hC78E;
      3: return 16'h07F0;
      default: return 16'hF800;
    endcase
  endfunction

  function automatic logic [5:0] ref_chk(input logic [15:0] d);
    logic [5:0] p;
    for (int j = 0; j < 5; j++) p[j] = ^(d & mask_of(j));
    p[5] = ^{d, p[4:0]};
    return p;
  endfunction

  function automatic logic [21:0] ref_code(input logic [15:0] d);
    logic [21:0] c;
    logic [5:0]  p;
    p = ref_chk(d);
    c = '0;
    c[0] = p[5];
    c[1] = p[0]; c[2] = p[1]; c[4] = p[2]; c[8] = p[3]; c[16] = p[4];
    for (int i = 0; i < 16; i++) c[DPOS[i]] = d[i];
    return c;
  endfunction

  function automatic logic [15:0] ref_data(input logic [21:0] c);
    logic [15:0] d;
    for (int i = 0; i < 16; i++) d[i] = c[DPOS[i]];
    return d;
  endfunction

  typedef struct {
    logic [5:0]  chk;
    logic [21:0] code;
  } enc_exp_t;

  typedef struct {
    logic [15:0] data;
    logic [21:0] code;
    logic [4:0]  syn;
    logic [1:0]  cls;
    string       req;
  } dec_exp_t;

  enc_exp_t enc_q[$];
  dec_exp_t dec_q[$];

  // drivers
  task automatic send_enc(input logic [15:0] d);
    enc_exp_t e;
    e.chk  = ref_chk(d);
    e.code = ref_code(d);
    enc_q.push_back(e);
    enc_in_valid = 1'b1;
    enc_in_data  = d;
    forever begin
      @(negedge clk);
      if (enc_in_ready) break;
    end
    @(posedge clk); #1;
    enc_in_valid = 1'b0;
  endtask

  task automatic send_dec(input logic [21:0] rx, input dec_exp_t e);
    dec_q.push_back(e);
    dec_in_valid = 1'b1;
    dec_in_code  = rx;
    forever begin
      @(negedge clk);
      if (dec_in_ready) break;
    end
    @(posedge clk); #1;
    dec_in_valid = 1'b0;
  endtask

  task automatic dec_clean(input logic [15:0] d);
    dec_exp_t e;
    e.data = d; e.code = ref_code(d); e.syn = 5'd0; e.cls = 2'd0; e.req = "R6";
    send_dec(ref_code(d), e);
  endtask

  task automatic dec_single(input logic [15:0] d, input int p);
    dec_exp_t e;
    logic [21:0] rx;
    rx = ref_code(d) ^ (22'd1 << p);
    e.data = d; e.code = ref_code(d);
    e.syn  = 5'(p);
    e.cls  = (p == 0) ? 2'd3 : 2'd1;
    e.req  = (p == 0) ? "R9" : "R7";
    send_dec(rx, e);
  endtask

  task automatic dec_double(input logic [15:0] d, input int p, input int q);
    dec_exp_t e;
    logic [21:0] rx;
    rx = ref_code(d) ^ (22'd1 << p) ^ (22'd1 << q);
    e.data = ref_data(rx); e.code = rx; e.syn = 5'(p ^ q); e.cls = 2'd2; e.req = "R8";
    send_dec(rx, e);
  endtask

  task automatic dec_beyond(input logic [15:0] d);
    dec_exp_t e;
    logic [21:0] rx;
    rx = ref_code(d) ^ (22'd1 << 21) ^ (22'd1 << 3) ^ 22'd1;
    e.data = ref_data(rx); e.code = rx; e.syn = 5'd22; e.cls = 2'd2; e.req = "R10";
    send_dec(rx, e);
  endtask

  // consumer ready: 0 free-running, 1 random, 2 held low
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      1:       begin enc_out_ready = lfsr[0]; dec_out_ready = lfsr[3]; end
      2:       begin enc_out_ready = 1'b0;    dec_out_ready = 1'b0;    end
      default: begin enc_out_ready = 1'b1;    dec_out_ready = 1'b1;    end
    endcase
  end

  // monitors
  bit          enc_stall = 1'b0;
  logic [27:0] enc_held;
  bit          dec_stall = 1'b0;
  logic [66:0] dec_held;

  always @(negedge clk) begin
    if (rst) begin
      enc_stall = 1'b0;
      dec_stall = 1'b0;
    end else begin
      if (enc_stall) begin
        check(enc_out_valid, "R4", "enc held valid", 64'(enc_out_valid), 64'd1);
        check({enc_out_check, enc_out_code} == enc_held, "R4", "enc held payload",
              64'({enc_out_check, enc_out_code}), 64'(enc_held));
      end
      if (enc_out_valid && enc_out_ready) begin
        if (enc_q.size() == 0) begin
          check(1'b0, "R4", "enc unexpected item", 64'(enc_out_code), 64'd0);
        end else begin
          enc_exp_t e;
          e = enc_q.pop_front();
          check(enc_out_check[4:0] == e.chk[4:0], "R1", "check bits",
                64'(enc_out_check[4:0]), 64'(e.chk[4:0]));
          check(enc_out_check[5] == e.chk[5], "R2", "overall bit",
                64'(enc_out_check[5]), 64'(e.chk[5]));
          check(enc_out_code == e.code, "R3", "codeword", 64'(enc_out_code), 64'(e.code));
        end
      end
      enc_stall = enc_out_valid && !enc_out_ready;
      enc_held  = {enc_out_check, enc_out_code};

      if (dec_stall) begin
        check(dec_out_valid, "R4", "dec held valid", 64'(dec_out_valid), 64'd1);
        check({dec_out_data, dec_out_code, dec_out_syndrome, dec_out_class} == dec_held,
              "R4", "dec held payload",
              64'({dec_out_data, dec_out_code, dec_out_syndrome, dec_out_class}), 64'(dec_held));
      end
      if (dec_out_valid && dec_out_ready) begin
        if (dec_q.size() == 0) begin
          check(1'b0, "R4", "dec unexpected item", 64'(dec_out_code), 64'd0);
        end else begin
          dec_exp_t e;
          e = dec_q.pop_front();
          check(dec_out_class == e.cls, e.req, "class", 64'(dec_out_class), 64'(e.cls));
          check(dec_out_syndrome == e.syn, e.req, "syndrome",
                64'(dec_out_syndrome), 64'(e.syn));
          check(dec_out_code == e.code, e.req, "codeword", 64'(dec_out_code), 64'(e.code));
          check(dec_out_data == e.data, "R11", "data", 64'(dec_out_data), 64'(e.data));
        end
      end
      dec_stall = dec_out_valid && !dec_out_ready;
      dec_held  = {dec_out_data, dec_out_code, dec_out_syndrome, dec_out_class};
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5: outputs empty while in reset
    check(!enc_out_valid && !dec_out_valid, "R5", "valid in reset",
          64'({enc_out_valid, dec_out_valid}), 64'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(enc_in_ready && dec_in_ready, "R4", "ready when empty",
          64'({enc_in_ready, dec_in_ready}), 64'h3);

    // R4: one-edge latency
    @(posedge clk); #1;
    begin
      enc_exp_t e;
      e.chk = ref_chk(16'h1234); e.code = ref_code(16'h1234);
      enc_q.push_back(e);
    end
    enc_in_valid = 1'b1;
    enc_in_data  = 16'h1234;
    @(negedge clk);
    check(!enc_out_valid, "R4", "valid before edge", 64'(enc_out_valid), 64'd0);
    @(posedge clk); #1;
    enc_in_valid = 1'b0;
    @(negedge clk);
    check(enc_out_valid, "R4", "valid after edge", 64'(enc_out_valid), 64'd1);
    @(posedge clk); #1;

    fork
      begin
        send_enc(16'h0000);
        send_enc(16'hFFFF);
        for (int i = 0; i < 16; i++) send_enc(16'd1 << i);
        for (int i = 0; i < 20; i++) send_enc(16'($urandom));
      end
      begin
        dec_clean(16'h0000);
        dec_clean(16'hBEEF);
        for (int p = 0; p < 22; p++) dec_single(16'hBEEF, p);
        for (int p = 0; p < 22; p++) dec_single(16'h0000, p);
        dec_double(16'hBEEF, 3, 5);
        dec_double(16'h1357, 0, 21);
        dec_double(16'hFFFF, 16, 8);
        dec_beyond(16'h5A5A);
      end
    join

    // back-pressure with random consumer ready
    bp_mode = 1;
    fork
      for (int i = 0; i < 40; i++) send_enc(16'($urandom));
      for (int i = 0; i < 40; i++) begin
        logic [15:0] d;
        d = 16'($urandom);
        if (i % 3 == 0) dec_clean(d);
        else if (i % 3 == 1) dec_single(d, i % 22);
        else dec_double(d, 1 + (i % 20), 21);
      end
    join
    wait (enc_q.size() == 0 && dec_q.size() == 0);
    @(posedge clk); #1;

    // R5: reset discards a held item
    bp_mode = 2;
    @(posedge clk); #1;
    send_enc(16'hCAFE);
    @(negedge clk);
    check(enc_out_valid, "R5", "item held before reset", 64'(enc_out_valid), 64'd1);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    enc_q.delete();
    @(negedge clk);
    check(!enc_out_valid, "R5", "item dropped by reset", 64'(enc_out_valid), 64'd0);
    bp_mode = 0;
    repeat (3) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule